// File: doc/BRIEF.md
# Unified Integer and Floating-Point Physical Register File

This block is the physical register storage of an out-of-order core. Integer and floating-point registers share one flat physical index space. The low indices, from 0 up to `NUM_INT-1`, name integer registers. The indices from `NUM_INT` up to `NUM_INT+NUM_FLOAT-1` name floating-point registers. The float bank is addressed with the index minus `NUM_INT`, so the first float index equals the integer register count. Float contents are kept as raw bit patterns, so a value view and a bit view of a float register are the same storage.

Each bank has one combinational read port and one write port. A write commits on the rising clock edge. Every port checks the class of its index and raises an error flag when the index belongs to the wrong class or lies beyond the last register. A separate classification port reports whether a given index is integer or float. Constant count outputs give the integer, float and total register counts.

The write ports are plain enables with no back-pressure: an enabled write is always taken in the cycle it is presented, unless it is dropped by a zero-slot or class rule below. A read never stalls.

Top module: `phys_regfile`

## Requirements
- R1: `cls_is_int` is 1 exactly when `cls_idx` < `NUM_INT`. `cls_is_float` is 1 exactly when `NUM_INT` <= `cls_idx` < `NUM_INT+NUM_FLOAT`. Both are 0 for any larger index.
- R2: `cnt_int`, `cnt_float` and `cnt_total` equal `NUM_INT`, `NUM_FLOAT` and their sum.
- R3: An enabled integer or float write of a legal index changes storage at the next rising edge. A read of that index on its own port then returns the data combinationally.
- R4: An integer write whose index equals `ZERO_IDX` leaves storage unchanged, so that register keeps reading 0.
- R5: Float index `NUM_INT+k` selects float slot k. That slot is separate from integer register k, and a write to one never changes the other.
- R6: With `FP_ZERO_SUPPRESS`=1, a float write whose slot offset equals `ZERO_IDX` (index `NUM_INT+ZERO_IDX`) is dropped.
- R7: The port's error flag is raised and the access is neutralised in these cases: an integer-port index at or above `NUM_INT`, or a float-port index below `NUM_INT` or at or above the total. Such a read returns 0 with its `_rd_err` at 1. Such a write has its `_wr_err` at 1 and changes no register.
- R8: A read of the index being written in the same cycle returns the value from before the write. There is no bypass.
- R9: While `rst` is high at a rising edge, all registers of both banks are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| int_rd_idx | input | IDX_W | Integer read index |
| int_rd_data | output | DATA_W | Integer read data |
| int_rd_err | output | 1 | Integer read index is illegal |
| int_wr_en | input | 1 | Integer write enable |
| int_wr_idx | input | IDX_W | Integer write index |
| int_wr_data | input | DATA_W | Integer write data |
| int_wr_err | output | 1 | Enabled integer write has an illegal index |
| fp_rd_idx | input | IDX_W | Float read index |
| fp_rd_data | output | DATA_W | Float read data (raw bits) |
| fp_rd_err | output | 1 | Float read index is illegal |
| fp_wr_en | input | 1 | Float write enable |
| fp_wr_idx | input | IDX_W | Float write index |
| fp_wr_data | input | DATA_W | Float write data (raw bits) |
| fp_wr_err | output | 1 | Enabled float write has an illegal index |
| cls_idx | input | IDX_W | Index to classify |
| cls_is_int | output | 1 | Index is an integer register |
| cls_is_float | output | 1 | Index is a float register |
| cnt_int | output | CNT_W | Number of integer registers |
| cnt_float | output | CNT_W | Number of float registers |
| cnt_total | output | CNT_W | Total number of registers |

## Verification
A bad write decode, such as a wrong base subtraction or a missing zero-slot or class gate, corrupts a register. The damage is only visible when that register is read back, which happens one edge later at the earliest. So every write is followed at once by a read of the same index. Aliasing between integer slot k and float slot k stays silent until the neighbouring bank is read, so those pairs are read back on both ports. Decode errors in the classification show up in the same cycle, so all 64 index values are checked.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FLT = 2'd1,
    CLS_BAD = 2'd2
  } prf_cls_e;
endpackage

// File: rtl/prf_class_decode.sv
module prf_class_decode
  import prf_pkg::*;
#(
  parameter int NUM_INT   = 24,
  parameter int NUM_TOTAL = 44,
  parameter int IDX_W     = 6
) (
  input  logic [IDX_W-1:0] idx,
  output prf_cls_e         cls
);
  localparam logic [IDX_W:0] INT_LIM = (IDX_W+1)'(NUM_INT);
  localparam logic [IDX_W:0] TOT_LIM = (IDX_W+1)'(NUM_TOTAL);

  logic [IDX_W:0] wide;
  assign wide = {1'b0, idx};

  always_comb begin
    if (wide < INT_LIM)      cls = CLS_INT;
    else if (wide < TOT_LIM) cls = CLS_FLT;
    else                     cls = CLS_BAD;
  end
endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
  parameter int DEPTH         = 24,
  parameter int DATA_W        = 64,
  parameter int ZERO_SUPPRESS = 1,
  parameter int ZERO_IDX      = 0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DEPTH-1:0][DATA_W-1:0] mem;
  logic drop;

  generate
    if (ZERO_SUPPRESS != 0) begin : g_zero_gate
      assign drop = (waddr == AW'(ZERO_IDX));
      // R4 (integer bank) / R6 (float bank): the zero slot never changes
      p_zero_slot_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == AW'(ZERO_IDX)) |=> $stable(mem));
    end else begin : g_no_gate
      assign drop = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (we && !drop) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R7: with no enabled write, storage is held
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mem));

  // R3: an accepted write lands in its slot
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (we && !drop) |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/phys_regfile.sv
module phys_regfile
  import prf_pkg::*;
#(
  parameter int NUM_INT          = 24,
  parameter int NUM_FLOAT        = 20,
  parameter int DATA_W           = 64,
  parameter int ZERO_IDX         = 0,
  parameter int FP_ZERO_SUPPRESS = 1,
  localparam int NUM_TOTAL = NUM_INT + NUM_FLOAT,
  localparam int IDX_W     = (NUM_TOTAL > 1) ? $clog2(NUM_TOTAL) : 1,
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  int_rd_idx,
  output logic [DATA_W-1:0] int_rd_data,
  output logic              int_rd_err,
  input  logic              int_wr_en,
  input  logic [IDX_W-1:0]  int_wr_idx,
  input  logic [DATA_W-1:0] int_wr_data,
  output logic              int_wr_err,
  input  logic [IDX_W-1:0]  fp_rd_idx,
  output logic [DATA_W-1:0] fp_rd_data,
  output logic              fp_rd_err,
  input  logic              fp_wr_en,
  input  logic [IDX_W-1:0]  fp_wr_idx,
  input  logic [DATA_W-1:0] fp_wr_data,
  output logic              fp_wr_err,
  input  logic [IDX_W-1:0]  cls_idx,
  output logic              cls_is_int,
  output logic              cls_is_float,
  output logic [CNT_W-1:0]  cnt_int,
  output logic [CNT_W-1:0]  cnt_float,
  output logic [CNT_W-1:0]  cnt_total
);
  localparam int INT_AW = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;
  localparam int FP_AW  = (NUM_FLOAT > 1) ? $clog2(NUM_FLOAT) : 1;
  localparam int NPORT  = 5;
  localparam logic [IDX_W-1:0] FP_BASE = IDX_W'(NUM_INT);

  // decoder slots: 0 int rd, 1 int wr, 2 fp rd, 3 fp wr, 4 classify
  logic [IDX_W-1:0] dec_idx [NPORT];
  prf_cls_e         dec_cls [NPORT];

  assign dec_idx[0] = int_rd_idx;
  assign dec_idx[1] = int_wr_idx;
  assign dec_idx[2] = fp_rd_idx;
  assign dec_idx[3] = fp_wr_idx;
  assign dec_idx[4] = cls_idx;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_dec
      prf_class_decode #(
        .NUM_INT  (NUM_INT),
        .NUM_TOTAL(NUM_TOTAL),
        .IDX_W    (IDX_W)
      ) u_dec (
        .idx(dec_idx[p]),
        .cls(dec_cls[p])
      );
    end
  endgenerate

  // bank offsets: float side removes the base
  logic [INT_AW-1:0] int_rd_off, int_wr_off;
  logic [FP_AW-1:0]  fp_rd_off, fp_wr_off;
  logic [IDX_W-1:0]  fp_rd_rel, fp_wr_rel;

  assign fp_rd_rel  = fp_rd_idx - FP_BASE;
  assign fp_wr_rel  = fp_wr_idx - FP_BASE;
  assign int_rd_off = INT_AW'(int_rd_idx);
  assign int_wr_off = INT_AW'(int_wr_idx);
  assign fp_rd_off  = FP_AW'(fp_rd_rel);
  assign fp_wr_off  = FP_AW'(fp_wr_rel);

  logic int_rd_ok, int_wr_ok, fp_rd_ok, fp_wr_ok;
  assign int_rd_ok = (dec_cls[0] == CLS_INT);
  assign int_wr_ok = (dec_cls[1] == CLS_INT);
  assign fp_rd_ok  = (dec_cls[2] == CLS_FLT);
  assign fp_wr_ok  = (dec_cls[3] == CLS_FLT);

  logic [DATA_W-1:0] int_bank_q, fp_bank_q;

  prf_bank #(
    .DEPTH        (NUM_INT),
    .DATA_W       (DATA_W),
    .ZERO_SUPPRESS(1),
    .ZERO_IDX     (ZERO_IDX)
  ) u_int_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (int_wr_en && int_wr_ok),
    .waddr(int_wr_off),
    .wdata(int_wr_data),
    .raddr(int_rd_off),
    .rdata(int_bank_q)
  );

  prf_bank #(
    .DEPTH        (NUM_FLOAT),
    .DATA_W       (DATA_W),
    .ZERO_SUPPRESS(FP_ZERO_SUPPRESS),
    .ZERO_IDX     (ZERO_IDX)
  ) u_fp_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (fp_wr_en && fp_wr_ok),
    .waddr(fp_wr_off),
    .wdata(fp_wr_data),
    .raddr(fp_rd_off),
    .rdata(fp_bank_q)
  );

  assign int_rd_data  = int_rd_ok ? int_bank_q : '0;
  assign fp_rd_data   = fp_rd_ok  ? fp_bank_q  : '0;
  assign int_rd_err   = !int_rd_ok;
  assign fp_rd_err    = !fp_rd_ok;
  assign int_wr_err   = int_wr_en && !int_wr_ok;
  assign fp_wr_err    = fp_wr_en && !fp_wr_ok;

  assign cls_is_int   = (dec_cls[4] == CLS_INT);
  assign cls_is_float = (dec_cls[4] == CLS_FLT);

  assign cnt_int   = CNT_W'(NUM_INT);
  assign cnt_float = CNT_W'(NUM_FLOAT);
  assign cnt_total = CNT_W'(NUM_TOTAL);

  // R1: an index is never both classes
  p_cls_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cls_is_int, cls_is_float}));

  // R7: a flagged read returns zero on both ports
  p_err_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (int_rd_err |-> int_rd_data == '0) and (fp_rd_err |-> fp_rd_data == '0));

  // R9: right after reset every readable register is zero
  p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (int_rd_data == '0 && fp_rd_data == '0));

  // R4: integer zero register always reads zero
  p_int_zero_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (int_rd_idx == IDX_W'(ZERO_IDX)) |-> int_rd_data == '0);
endmodule

// File: tb/phys_regfile_test.sv
module phys_regfile_test;
  localparam int NI = 24;
  localparam int NF = 20;
  localparam int IW = 6;
  localparam int DW = 64;

  logic          clk = 0;
  logic          rst = 1;
  logic [IW-1:0] int_rd_idx = '0, int_wr_idx = '0, fp_rd_idx = '0, fp_wr_idx = '0, cls_idx = '0;
  logic [DW-1:0] int_wr_data = '0, fp_wr_data = '0;
  logic          int_wr_en = 0, fp_wr_en = 0;
  logic [DW-1:0] int_rd_data, fp_rd_data;
  logic          int_rd_err, fp_rd_err, int_wr_err, fp_wr_err, cls_is_int, cls_is_float;
  logic [IW:0]   cnt_int, cnt_float, cnt_total;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  phys_regfile #(.NUM_INT(NI), .NUM_FLOAT(NF), .DATA_W(DW), .ZERO_IDX(0), .FP_ZERO_SUPPRESS(1)) uut (
    .clk(clk), .rst(rst),
    .int_rd_idx(int_rd_idx), .int_rd_data(int_rd_data), .int_rd_err(int_rd_err),
    .int_wr_en(int_wr_en), .int_wr_idx(int_wr_idx), .int_wr_data(int_wr_data), .int_wr_err(int_wr_err),
    .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data), .fp_rd_err(fp_rd_err),
    .fp_wr_en(fp_wr_en), .fp_wr_idx(fp_wr_idx), .fp_wr_data(fp_wr_data), .fp_wr_err(fp_wr_err),
    .cls_idx(cls_idx), .cls_is_int(cls_is_int), .cls_is_float(cls_is_float),
    .cnt_int(cnt_int), .cnt_float(cnt_float), .cnt_total(cnt_total)
  );

  typedef struct packed {
    logic          fp;
    logic [IW-1:0] idx;
    logic [DW-1:0] wdata;
    logic [DW-1:0] exp;
    logic          err;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{1'b0, 6'd3,  64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 4'd3},
    '{1'b0, 6'd0,  64'hFFFF_0000_FFFF_0000, 64'h0,                   1'b0, 4'd4},
    '{1'b0, 6'd23, 64'hDEAD_BEEF_0000_0017, 64'hDEAD_BEEF_0000_0017, 1'b0, 4'd3},
    '{1'b0, 6'd24, 64'h5555_5555_5555_5555, 64'h0,                   1'b1, 4'd7},
    '{1'b1, 6'd25, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, 4'd3},
    '{1'b1, 6'd24, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0,                   1'b0, 4'd6},
    '{1'b1, 6'd43, 64'hC000_0000_0000_002B, 64'hC000_0000_0000_002B, 1'b0, 4'd3},
    '{1'b1, 6'd44, 64'h1234_1234_1234_1234, 64'h0,                   1'b1, 4'd7},
    '{1'b1, 6'd10, 64'h7777_7777_7777_7777, 64'h0,                   1'b1, 4'd7},
    '{1'b0, 6'd50, 64'h9999_9999_9999_9999, 64'h0,                   1'b1, 4'd7}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    #1;

    // R9: reset state
    int_rd_idx = 6'd3;  fp_rd_idx = 6'd25; #1;
    chk("R9", int_rd_data, '0);
    chk("R9", fp_rd_data, '0);
    int_rd_idx = 6'd23; fp_rd_idx = 6'd43; #1;
    chk("R9", int_rd_data, '0);
    chk("R9", fp_rd_data, '0);

    // R2: counts
    chk("R2", 64'(cnt_int), 64'd24);
    chk("R2", 64'(cnt_float), 64'd20);
    chk("R2", 64'(cnt_total), 64'd44);

    // R1: classification over every index
    for (int i = 0; i < 64; i++) begin
      cls_idx = IW'(i);
      #1;
      chk("R1", {62'd0, cls_is_int, cls_is_float},
          {62'd0, (i < NI) ? 1'b1 : 1'b0, (i >= NI && i < NI + NF) ? 1'b1 : 1'b0});
    end

    // table of write-then-readback vectors (R3, R4, R6, R7)
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VT[v].req);
      if (VT[v].fp) begin
        fp_wr_en = 1; fp_wr_idx = VT[v].idx; fp_wr_data = VT[v].wdata;
        #1;
        chk(tag, 64'(fp_wr_err), 64'(VT[v].err));
        tick();
        fp_wr_en = 0; fp_rd_idx = VT[v].idx;
        #1;
        chk(tag, fp_rd_data, VT[v].exp);
        chk(tag, 64'(fp_rd_err), 64'(VT[v].err));
      end else begin
        int_wr_en = 1; int_wr_idx = VT[v].idx; int_wr_data = VT[v].wdata;
        #1;
        chk(tag, 64'(int_wr_err), 64'(VT[v].err));
        tick();
        int_wr_en = 0; int_rd_idx = VT[v].idx;
        #1;
        chk(tag, int_rd_data, VT[v].exp);
        chk(tag, 64'(int_rd_err), 64'(VT[v].err));
      end
    end

    // R7: rejected writes left legal registers intact
    int_rd_idx = 6'd10; fp_rd_idx = 6'd24; #1;
    chk("R7", int_rd_data, '0);
    chk("R6", fp_rd_data, '0);

    // R5: int slot 1 versus float index 25 (slot 1)
    int_wr_en = 1; int_wr_idx = 6'd1; int_wr_data = 64'h1111_1111_1111_1111;
    tick();
    int_wr_en = 0; int_rd_idx = 6'd1; fp_rd_idx = 6'd25; #1;
    chk("R5", int_rd_data, 64'h1111_1111_1111_1111);
    chk("R5", fp_rd_data, 64'h3FF0_0000_0000_0000);
    fp_wr_en = 1; fp_wr_idx = 6'd25; fp_wr_data = 64'h2222_2222_2222_2222;
    tick();
    fp_wr_en = 0; #1;
    chk("R5", int_rd_data, 64'h1111_1111_1111_1111);
    chk("R5", fp_rd_data, 64'h2222_2222_2222_2222);

    // R8: same-cycle read returns old value
    int_wr_en = 1; int_wr_idx = 6'd3; int_wr_data = 64'hCAFE_0000_0000_0003; int_rd_idx = 6'd3;
    fp_wr_en = 1; fp_wr_idx = 6'd43; fp_wr_data = 64'hBEEF_0000_0000_0043; fp_rd_idx = 6'd43;
    #1;
    chk("R8", int_rd_data, 64'h0123_4567_89AB_CDEF);
    chk("R8", fp_rd_data, 64'hC000_0000_0000_002B);
    tick();
    int_wr_en = 0; fp_wr_en = 0; #1;
    chk("R8", int_rd_data, 64'hCAFE_0000_0000_0003);
    chk("R8", fp_rd_data, 64'hBEEF_0000_0000_0043);

    // R9: reset clears written registers
    rst = 1;
    tick();
    rst = 0;
    int_rd_idx = 6'd3; fp_rd_idx = 6'd43; #1;
    chk("R9", int_rd_data, '0);
    chk("R9", fp_rd_data, '0);
    int_rd_idx = 6'd23; fp_rd_idx = 6'd25; #1;
    chk("R9", int_rd_data, '0);
    chk("R9", fp_rd_data, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule